// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Port

This block is the character engine of an asynchronous serial port. It sends on `txd_o` and receives on `rxd_i`. All of its timing comes from a baud enable, `baud_tick_i`, that pulses 16 times per bit period (the oversampling factor `OVS`). Frame generation and the tick source are kept separate, so one tick generator can serve several ports. Software sees the block as a small set of register fields: transmit byte and ninth bit, received byte and ninth bit, receive enable, address-filter enable, and three sticky flags. A flag stays set until the matching clear input is pulsed.

There are two frame lengths. The short frame is one start bit, eight data bits and one stop bit. The long frame places a ninth data bit between the data and the stop bit. The receiver finds the start of a frame from a falling edge of the input. It decides each bit by a majority vote of three samples taken at the middle of the bit. A start bit that does not hold low through the vote is discarded. A frame that completes while the previous one is still unread is dropped. When the address filter is enabled, a frame whose ninth bit (or stop bit, for short frames) is 0 does not raise the receive flag. This lets a node ignore data that is addressed to other nodes.

Top module: `serial_port_core`

## Requirements
- R1: After reset, `txd_o` is 1, all three flags are 0, and `rx_data_o` and `rx_bit9_o` are 0.
- R2: A receive starts on a 1-to-0 change of the synchronized input, seen at a tick while `rx_en_i` is 1. If the vote for the start bit gives 1, the receiver returns to idle and no flag or data changes. The next real frame is then received normally.
- R3: A bit is decided by majority over the samples taken at counter states OVS/2-1, OVS/2 and OVS/2+1 of its 16-state bit period. A disturbance lasting one tick inside that window does not change the received bit.
- R4: `mode_i[1]` = 0 selects the short frame: start 0, eight data bits LSB first, stop 1. On receive, the stop bit is stored in `rx_bit9_o`.
- R5: `mode_i[1]` = 1 selects the long frame. The ninth bit goes out between the data and the stop bit, taken from `tx_bit9_i` as captured at the write. On receive, the ninth bit is stored in `rx_bit9_o`.
- R6: The receive flag rises at the stop-bit vote, about halfway through the stop bit. It does not rise earlier in the frame. `rx_data_o` and `rx_bit9_o` change only in that same cycle.
- R7: A frame that completes while `rx_flag_o` is 1 is discarded. `rx_data_o` and `rx_bit9_o` keep their values.
- R8: With `mp_en_i` = 1, a frame is accepted only if its ninth bit is 1 (long frame) or its stop bit is 1 (short frame). Otherwise the receive flag stays 0 and the data is unchanged.
- R9: `ferr_o` is set by a received stop bit of 0. Later valid frames leave it set, and only `ferr_clr_i` clears it.
- R10: A write with `tx_wr_i` while idle begins the start bit at the next bit boundary, no more than one bit period later. `tx_flag_o` rises when the stop bit begins. A write during a transmission is ignored, and no second frame follows.
- R11: The receive and transmit flags are cleared only by their clear inputs, and stay set otherwise.
- R12: With `rx_en_i` = 0, incoming frames are ignored: no flag rises and the data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick_i | input | 1 | One-cycle enable, OVS pulses per bit period |
| mode_i | input | 2 | Frame mode; bit 1 selects the long frame |
| rx_en_i | input | 1 | Receive enable |
| mp_en_i | input | 1 | Address-filter enable |
| tx_wr_i | input | 1 | Transmit data write strobe |
| tx_data_i | input | DATA_W | Transmit byte |
| tx_bit9_i | input | 1 | Ninth transmit bit for long frames |
| rx_flag_clr_i | input | 1 | Clears the receive flag |
| tx_flag_clr_i | input | 1 | Clears the transmit flag |
| ferr_clr_i | input | 1 | Clears the framing-error flag |
| rxd_i | input | 1 | Serial input (asynchronous) |
| txd_o | output | 1 | Serial output, idles high |
| rx_data_o | output | DATA_W | Last accepted received byte |
| rx_bit9_o | output | 1 | Ninth bit or stop bit of the last accepted frame |
| rx_flag_o | output | 1 | Sticky receive flag |
| tx_flag_o | output | 1 | Sticky transmit flag |
| ferr_o | output | 1 | Sticky framing-error flag |

## Verification
The bench uses the defaults: eight data bits, sixteen ticks per bit and a two-stage input synchronizer. The tick runs at half the clock rate, so both the gating by the enable and the 7/8/9 vote positions are exercised exactly as configured. With sixteen states per bit, one-tick disturbances can be placed inside the vote window, and the stop bit can be cut short before its vote. This makes the mid-stop timing of the receive flag observable at the ports.

// File: rtl/sport_pkg.sv
package sport_pkg;

    typedef enum logic [1:0] {
        FRM_SHORT_A = 2'b00,
        FRM_SHORT_B = 2'b01,
        FRM_LONG_A  = 2'b10,
        FRM_LONG_B  = 2'b11
    } frame_mode_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic ninth;
        logic stop_ok;
    } rx_tail_t;

    function automatic logic is_long(input logic [1:0] mode);
        return mode[1];
    endfunction

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sport_rx.sv
module sport_rx
    import sport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  logic              en,
    input  logic              long_fr,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output rx_tail_t          tail
);

    localparam int CW  = $clog2(OVS);
    localparam int BW  = $clog2(DATA_W + 4);
    localparam int MID = OVS / 2;
    localparam logic [CW-1:0] S_A   = CW'(MID - 1);
    localparam logic [CW-1:0] S_B   = CW'(MID);
    localparam logic [CW-1:0] S_C   = CW'(MID + 1);
    localparam logic [CW-1:0] C_TOP = CW'(OVS - 1);
    localparam logic [BW-1:0] IDX_NINE  = BW'(DATA_W + 1);
    localparam logic [BW-1:0] IDX_LONG  = BW'(DATA_W + 2);
    localparam logic [BW-1:0] IDX_SHORT = BW'(DATA_W + 1);

    rx_state_e         state;
    logic              last_s;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     idx;
    logic [BW-1:0]     idx_last;
    logic [DATA_W-1:0] shreg;
    logic              ninth_q;
    logic              smp_a;
    logic              smp_b;
    logic              voted;
    logic              falling;

    always_comb begin
        voted    = vote3(smp_a, smp_b, rxd);
        idx_last = long_fr ? IDX_LONG : IDX_SHORT;
        falling  = tick && en && last_s && !rxd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            last_s  <= 1'b1;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            ninth_q <= 1'b0;
            smp_a   <= 1'b1;
            smp_b   <= 1'b1;
            done    <= 1'b0;
            data    <= '0;
            tail    <= '0;
        end else begin
            done <= 1'b0;
            if (tick) last_s <= rxd;
            unique case (state)
                RX_IDLE: begin
                    if (falling) begin
                        state <= RX_BUSY;
                        cnt   <= CW'(1);
                        idx   <= '0;
                    end
                end
                RX_BUSY: begin
                    if (!en) begin
                        state <= RX_IDLE;
                    end else if (tick) begin
                        cnt <= (cnt == C_TOP) ? '0 : cnt + 1'b1;
                        if (cnt == S_A) smp_a <= rxd;
                        if (cnt == S_B) smp_b <= rxd;
                        if (cnt == S_C) begin
                            idx <= idx + 1'b1;
                            if (idx == '0) begin
                                if (voted) state <= RX_IDLE;
                            end else if (idx == idx_last) begin
                                done         <= 1'b1;
                                data         <= shreg;
                                tail.stop_ok <= voted;
                                tail.ninth   <= long_fr ? ninth_q : voted;
                                state        <= RX_IDLE;
                            end else if (idx == IDX_NINE) begin
                                ninth_q <= voted;
                            end else begin
                                shreg <= {voted, shreg[DATA_W-1:1]};
                            end
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("receive completion longer than one cycle"); // R6

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> state == RX_IDLE) else $error("receiver still busy after completion"); // R2

endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              long_fr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wninth,
    output logic              txd,
    output logic              stop_go
);

    localparam int FW = DATA_W + 3;
    localparam int CW = $clog2(OVS);
    localparam int NW = $clog2(FW + 1);
    localparam logic [CW-1:0] C_TOP   = CW'(OVS - 1);
    localparam logic [NW-1:0] N_LONG  = NW'(DATA_W + 3);
    localparam logic [NW-1:0] N_SHORT = NW'(DATA_W + 2);

    logic [CW-1:0] div;
    logic [FW-1:0] sh;
    logic [NW-1:0] left;
    logic          busy;
    logic          bound;

    always_comb bound = tick && (div == C_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            div     <= '0;
            sh      <= '1;
            left    <= '0;
            busy    <= 1'b0;
            txd     <= 1'b1;
            stop_go <= 1'b0;
        end else begin
            stop_go <= 1'b0;
            if (tick) div <= (div == C_TOP) ? '0 : div + 1'b1;
            if (!busy) begin
                if (wr) begin
                    busy <= 1'b1;
                    sh   <= {1'b1, (long_fr ? wninth : 1'b1), wdata, 1'b0};
                    left <= long_fr ? N_LONG : N_SHORT;
                end
            end else if (bound) begin
                if (left != '0) begin
                    txd  <= sh[0];
                    sh   <= {1'b1, sh[FW-1:1]};
                    left <= left - 1'b1;
                    if (left == NW'(1)) stop_go <= 1'b1;
                end else begin
                    busy <= 1'b0;
                end
            end
        end
    end

    AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd) else $error("line not high while idle"); // R10

    AST_STOP_IS_HIGH: assert property (@(posedge clk) disable iff (rst)
        stop_go |-> txd) else $error("stop bit driven low"); // R4

    AST_BUSY_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        busy && !bound |=> $stable(sh)) else $error("frame changed between boundaries"); // R10

endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
    import sport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick_i,
    input  logic [1:0]        mode_i,
    input  logic              rx_en_i,
    input  logic              mp_en_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_bit9_i,
    input  logic              rx_flag_clr_i,
    input  logic              tx_flag_clr_i,
    input  logic              ferr_clr_i,
    input  logic              rxd_i,
    output logic              txd_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_bit9_o,
    output logic              rx_flag_o,
    output logic              tx_flag_o,
    output logic              ferr_o
);

    logic              long_fr;
    logic              rxd_s;
    logic              rx_done;
    logic [DATA_W-1:0] rx_word;
    rx_tail_t          rx_tail;
    logic              accept;
    logic              tx_stop_go;

    always_comb begin
        long_fr = is_long(mode_i);
        accept  = rx_done && !rx_flag_o && (!mp_en_i || rx_tail.ninth);
    end

    sport_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd_i),
        .q   (rxd_s)
    );

    sport_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (baud_tick_i),
        .rxd     (rxd_s),
        .en      (rx_en_i),
        .long_fr (long_fr),
        .done    (rx_done),
        .data    (rx_word),
        .tail    (rx_tail)
    );

    sport_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .tick    (baud_tick_i),
        .long_fr (long_fr),
        .wr      (tx_wr_i),
        .wdata   (tx_data_i),
        .wninth  (tx_bit9_i),
        .txd     (txd_o),
        .stop_go (tx_stop_go)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data_o <= '0;
            rx_bit9_o <= 1'b0;
            rx_flag_o <= 1'b0;
            tx_flag_o <= 1'b0;
            ferr_o    <= 1'b0;
        end else begin
            if (accept) begin
                rx_data_o <= rx_word;
                rx_bit9_o <= rx_tail.ninth;
                rx_flag_o <= 1'b1;
            end else if (rx_flag_clr_i) begin
                rx_flag_o <= 1'b0;
            end
            if (rx_done && !rx_tail.stop_ok) ferr_o <= 1'b1;
            else if (ferr_clr_i)             ferr_o <= 1'b0;
            if (tx_stop_go)         tx_flag_o <= 1'b1;
            else if (tx_flag_clr_i) tx_flag_o <= 1'b0;
        end
    end

    AST_RXF_STICKY: assert property (@(posedge clk) disable iff (rst)
        rx_flag_o && !rx_flag_clr_i |=> rx_flag_o) else $error("receive flag dropped"); // R11

    AST_TXF_STICKY: assert property (@(posedge clk) disable iff (rst)
        tx_flag_o && !tx_flag_clr_i |=> tx_flag_o) else $error("transmit flag dropped"); // R11

    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ferr_o && !ferr_clr_i |=> ferr_o) else $error("framing flag dropped"); // R9

    AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        rx_flag_o |=> $stable(rx_data_o) && $stable(rx_bit9_o)) else $error("unread data overwritten"); // R7

    AST_DATA_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data_o) |-> rx_flag_o && !$past(rx_flag_o)) else $error("data moved without flag rise"); // R6

    AST_MP_FILTER: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_flag_o) && $past(mp_en_i) |-> rx_bit9_o) else $error("filtered frame accepted"); // R8

endmodule

// File: tb/serial_port_core_bench.sv
module serial_port_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] mode = 2'b01;
    logic       rx_en = 1'b1;
    logic       mp_en = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_bit9 = 1'b0;
    logic       rxf_clr = 1'b0;
    logic       txf_clr = 1'b0;
    logic       fe_clr = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_flag;
    logic       tx_flag;
    logic       ferr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= ~tick;
    end

    serial_port_core u_serial_port_core (
        .clk           (clk),
        .rst           (rst),
        .baud_tick_i   (tick),
        .mode_i        (mode),
        .rx_en_i       (rx_en),
        .mp_en_i       (mp_en),
        .tx_wr_i       (tx_wr),
        .tx_data_i     (tx_data),
        .tx_bit9_i     (tx_bit9),
        .rx_flag_clr_i (rxf_clr),
        .tx_flag_clr_i (txf_clr),
        .ferr_clr_i    (fe_clr),
        .rxd_i         (rxd),
        .txd_o         (txd),
        .rx_data_o     (rx_data),
        .rx_bit9_o     (rx_bit9),
        .rx_flag_o     (rx_flag),
        .tx_flag_o     (tx_flag),
        .ferr_o        (ferr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            do @(negedge clk); while (!tick);
        end
    endtask

    function automatic logic [10:0] fr10(input logic [7:0] d, input logic stp);
        return {1'b1, stp, d, 1'b0};
    endfunction

    function automatic logic [10:0] fr11(input logic [7:0] d, input logic b9, input logic stp);
        return {stp, b9, d, 1'b0};
    endfunction

    task automatic rx_send(input logic [10:0] fr, input int n, input logic [10:0] gmask, input int last_len);
        for (int i = 0; i < n; i++) begin
            if (gmask[i]) begin
                rxd = fr[i];  wait_ticks(8);
                rxd = ~fr[i]; wait_ticks(1);
                rxd = fr[i];  wait_ticks(7);
            end else begin
                rxd = fr[i];
                wait_ticks((i == n - 1) ? last_len : 16);
            end
        end
        rxd = 1'b1;
    endtask

    task automatic pulse_rxclr();
        @(negedge clk); rxf_clr = 1'b1;
        @(negedge clk); rxf_clr = 1'b0;
    endtask

    task automatic tx_write(input logic [7:0] d, input logic b9);
        @(negedge clk); tx_data = d; tx_bit9 = b9; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 txd", txd, 1);
        chk("R1 rx_flag", rx_flag, 0);
        chk("R1 tx_flag", tx_flag, 0);
        chk("R1 ferr", ferr, 0);
        chk("R1 rx_data", rx_data, 0);
        chk("R1 rx_bit9", rx_bit9, 0);
    endtask

    task automatic t_rx_short();
        mode = 2'b01;
        rx_send(fr10(8'hA5, 1'b1), 10, '0, 16);
        chk("R4 short data", rx_data, 8'hA5);
        chk("R4 stop stored", rx_bit9, 1);
        chk("R4 flag", rx_flag, 1);
        chk("R4 no ferr", ferr, 0);
        pulse_rxclr();
        chk("R11 rx clear", rx_flag, 0);
        wait_ticks(20);
        chk("R11 rx stays clear", rx_flag, 0);
    endtask

    task automatic t_flag_timing();
        rx_send(fr10(8'h3C, 1'b1), 10, '0, 4);
        chk("R6 flag not before stop vote", rx_flag, 0);
        chk("R6 data unchanged before flag", rx_data, 8'hA5);
        wait_ticks(12);
        chk("R6 flag at mid stop", rx_flag, 1);
        chk("R6 data with flag", rx_data, 8'h3C);
        pulse_rxclr();
    endtask

    task automatic t_false_start();
        rxd = 1'b0; wait_ticks(4);
        rxd = 1'b1; wait_ticks(40);
        chk("R2 false start no flag", rx_flag, 0);
        chk("R2 false start data kept", rx_data, 8'h3C);
        rx_send(fr10(8'h96, 1'b1), 10, '0, 16);
        chk("R2 recovery data", rx_data, 8'h96);
        chk("R2 recovery flag", rx_flag, 1);
        pulse_rxclr();
    endtask

    task automatic t_glitch();
        rx_send(fr10(8'h81, 1'b1), 10, 11'b00000000110, 16);
        chk("R3 vote data", rx_data, 8'h81);
        chk("R3 vote flag", rx_flag, 1);
        pulse_rxclr();
    endtask

    task automatic t_rx_long();
        mode = 2'b10;
        rx_send(fr11(8'h5A, 1'b0, 1'b1), 11, '0, 16);
        chk("R5 long data", rx_data, 8'h5A);
        chk("R5 ninth zero", rx_bit9, 0);
        chk("R5 flag", rx_flag, 1);
        wait_ticks(4);
        rx_send(fr11(8'h11, 1'b1, 1'b1), 11, '0, 16);
        chk("R7 overrun data kept", rx_data, 8'h5A);
        chk("R7 overrun ninth kept", rx_bit9, 0);
        chk("R7 flag held", rx_flag, 1);
        pulse_rxclr();
    endtask

    task automatic t_mp_long();
        mode = 2'b11; mp_en = 1'b1;
        rx_send(fr11(8'h22, 1'b0, 1'b1), 11, '0, 16);
        chk("R8 ninth 0 filtered", rx_flag, 0);
        chk("R8 filtered data kept", rx_data, 8'h5A);
        rx_send(fr11(8'h77, 1'b1, 1'b1), 11, '0, 16);
        chk("R8 ninth 1 accepted", rx_flag, 1);
        chk("R8 accepted data", rx_data, 8'h77);
        chk("R8 accepted ninth", rx_bit9, 1);
        pulse_rxclr();
    endtask

    task automatic t_mp_short_ferr();
        mode = 2'b01; mp_en = 1'b1;
        rx_send(fr10(8'h44, 1'b0), 10, '0, 16);
        wait_ticks(20);
        chk("R8 bad stop filtered", rx_flag, 0);
        chk("R9 ferr set", ferr, 1);
        rx_send(fr10(8'h55, 1'b1), 10, '0, 16);
        chk("R8 good stop accepted", rx_data, 8'h55);
        chk("R9 ferr sticky", ferr, 1);
        mp_en = 1'b0;
        pulse_rxclr();
        @(negedge clk); fe_clr = 1'b1;
        @(negedge clk); fe_clr = 1'b0;
        chk("R9 ferr cleared", ferr, 0);
    endtask

    task automatic t_rx_disabled();
        rx_en = 1'b0;
        rx_send(fr10(8'hEE, 1'b1), 10, '0, 16);
        wait_ticks(8);
        chk("R12 no flag", rx_flag, 0);
        chk("R12 data kept", rx_data, 8'h55);
        rx_en = 1'b1;
        wait_ticks(4);
    endtask

    task automatic t_tx(input logic [1:0] md, input logic [7:0] d, input logic b9, input int n, input bit poke);
        logic [10:0] got;
        logic [10:0] expv;
        int lat;
        bit idle_ok;
        got = '1;
        mode = md;
        expv = (n == 10) ? fr10(d, 1'b1) : fr11(d, b9, 1'b1);
        tx_write(d, b9);
        lat = 0;
        do begin wait_ticks(1); lat++; end while (txd !== 1'b0 && lat < 40);
        chk("R10 start latency", lat <= 18, 1);
        wait_ticks(8);
        got[0] = txd;
        for (int i = 1; i < n; i++) begin
            wait_ticks(16);
            got[i] = txd;
            if (i == n - 2) chk("R10 tx flag before stop", tx_flag, 0);
            if (i == n - 1) chk("R10 tx flag at stop", tx_flag, 1);
            if (poke && i == 3) tx_write(8'h00, 1'b0);
        end
        if (n == 10) chk("R4 tx short frame", got[9:0], expv[9:0]);
        else         chk("R5 tx long frame", got, expv);
        idle_ok = 1'b1;
        for (int k = 0; k < 40; k++) begin
            wait_ticks(1);
            if (txd !== 1'b1) idle_ok = 1'b0;
        end
        chk("R10 idle after frame", idle_ok, 1);
        chk("R11 tx flag held", tx_flag, 1);
        @(negedge clk); txf_clr = 1'b1;
        @(negedge clk); txf_clr = 1'b0;
        chk("R11 tx flag cleared", tx_flag, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        wait_ticks(20);
        t_rx_short();
        t_flag_timing();
        t_false_start();
        t_glitch();
        t_rx_long();
        t_mp_long();
        t_mp_short_ferr();
        t_rx_disabled();
        t_tx(2'b01, 8'hC3, 1'b0, 10, 1'b1);
        t_tx(2'b10, 8'h0F, 1'b1, 11, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule